// File: doc/BRIEF.md
# Video Scan-Line Binary Sampler

This block turns the active part of one video scan line into a row of binary picture elements. A programmable slot timer cuts the line into slots of equal length. Each incoming video sample is compared digitally against one of 32 threshold levels. A slot's bit is 1 when any sample inside that slot rose above the threshold, and 0 when none did.

Completed bits are packed into 16-bit words, with the earliest slot in bit 0. A word is handed to a one-entry output buffer when 16 slots have been collected. It is also handed over when blanking begins with a partly filled word. The output buffer raises a ready flag that stays up until the consumer acknowledges it.

A line of 8 to 96 elements therefore yields between one and six words. The host sets the slot length through a divider word and the level through a threshold code. A loss of data, when a new word arrives before the previous one was taken, is latched in a sticky overrun flag.

Top module: `scanline_binarizer`

## Requirements
- R1: With divider word D, every slot lasts D+1 clock cycles. The first slot starts on the first clock cycle after blanking ends.
- R2: The threshold level is the 5-bit threshold code times 8, that is the code placed in the top five bits of the 8-bit sample. A sample counts as a hit only when it is strictly greater than the level, so a sample equal to the level gives no hit.
- R3: A slot's bit is 1 if at least one sample in any cycle of that slot is a hit. The hit memory is cleared at the end of each slot, so a hit never carries into the next slot.
- R4: Within a word, the bit at position j (0 to 15) holds the j-th slot collected into that word. A word is issued in the cycle that completes its 16th slot.
- R5: When blanking begins and a word is partly filled, that word is issued with all unfilled high bits zero. A slot that is still incomplete when blanking begins is discarded. If no slot bits are pending when blanking begins, no word is issued.
- R6: word_rdy rises with each issued word and stays high, with word_out stable, until word_ack is seen high at a clock edge.
- R7: If a word is issued while word_rdy is high and word_ack is low, overrun becomes 1. overrun stays 1 until reset, and word_out takes the newer word.
- R8: While hblank or vblank is high, video samples are ignored. The slot timer is held at the divider value and the bit counter is held at zero.
- R9: After reset, word_out is 0, word_rdy is 0 and overrun is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| video_in | input | 8 | Digitized video sample code |
| hblank | input | 1 | Horizontal blanking, high between lines |
| vblank | input | 1 | Vertical blanking, high between fields |
| div_word | input | 8 | Slot length minus one, in clock cycles |
| thr_code | input | 5 | Threshold code, one of 32 levels |
| word_ack | input | 1 | Consumer acknowledge of the buffered word |
| word_out | output | 16 | Buffered binary word |
| word_rdy | output | 1 | Buffered word is available |
| overrun | output | 1 | Sticky flag for a word lost before acknowledge |

## Verification
A slot's bit is due at the clock edge that ends its (D+1)-th cycle. A full word shows on word_out and word_rdy one edge after its 16th slot ends, and a partial word shows one edge after the first blanking cycle. The bench never tries to predict those edges directly. Instead, it samples on falling edges, takes each word when word_rdy is seen high, and then acknowledges it. The acknowledge clears word_rdy on the next rising edge. Words are checked in order against values worked out from the stimulus pattern, and the word count of each line is compared with the number of slots divided by 16, rounded up.

// File: rtl/slc_pkg.sv
package slc_pkg;

    typedef enum logic [0:0] {
        PH_BLANK  = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_t;

    typedef struct packed {
        logic tick;
        logic bit_val;
    } slot_evt_t;

    function automatic int unsigned words_for(input int unsigned slots, input int unsigned wsz);
        return (slots + wsz - 1) / wsz;
    endfunction

endpackage

// File: rtl/slc_slot_timer.sv
module slc_slot_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  slc_pkg::phase_t  phase,
    input  logic [DIV_W-1:0] div_word,
    output logic             tick,
    output logic [DIV_W-1:0] cnt
);
    import slc_pkg::*;

    assign tick = (phase == PH_ACTIVE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (phase == PH_BLANK || tick) begin
            cnt <= div_word;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/slc_packer.sv
module slc_packer #(
    parameter int SMP_W  = 8,
    parameter int THR_W  = 5,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  slc_pkg::phase_t   phase,
    input  logic              tick,
    input  logic [SMP_W-1:0]  video_in,
    input  logic [THR_W-1:0]  thr_code,
    output logic              load,
    output logic [WORD_W-1:0] load_word
);
    import slc_pkg::*;

    localparam int CNT_W = $clog2(WORD_W);
    localparam int PAD_W = SMP_W - THR_W;

    logic [SMP_W-1:0]  level;
    logic              hit;
    logic              latch_q;
    logic [WORD_W-1:0] sreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              blank_q;
    slot_evt_t         evt;
    logic              full_flush;
    logic              end_flush;
    logic [WORD_W-1:0] filled;

    generate
        if (PAD_W > 0) begin : g_pad
            assign level = {thr_code, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign level = thr_code[THR_W-1 -: SMP_W];
        end
    endgenerate

    assign hit         = (phase == PH_ACTIVE) && (video_in > level);
    assign evt.tick    = tick;
    assign evt.bit_val = latch_q | hit;

    assign full_flush = evt.tick && (bitcnt == CNT_W'(WORD_W - 1));
    assign end_flush  = (phase == PH_BLANK) && !blank_q && (bitcnt != '0);
    assign load       = full_flush | end_flush;

    always_comb begin
        filled         = sreg;
        filled[bitcnt] = evt.bit_val;
    end

    assign load_word = full_flush ? filled : sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            sreg    <= '0;
            bitcnt  <= '0;
            blank_q <= 1'b1;
        end else begin
            blank_q <= (phase == PH_BLANK);
            if (phase == PH_BLANK) begin
                latch_q <= 1'b0;
                sreg    <= '0;
                bitcnt  <= '0;
            end else if (evt.tick) begin
                latch_q <= 1'b0;
                if (full_flush) begin
                    sreg   <= '0;
                    bitcnt <= '0;
                end else begin
                    sreg   <= filled;
                    bitcnt <= bitcnt + 1'b1;
                end
            end else begin
                latch_q <= evt.bit_val;
            end
        end
    end
endmodule

// File: rtl/slc_out_buf.sv
module slc_out_buf #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              ack,
    output logic [WORD_W-1:0] word_out,
    output logic              word_rdy,
    output logic              overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_out <= '0;
            word_rdy <= 1'b0;
            overrun  <= 1'b0;
        end else if (load) begin
            word_out <= load_word;
            word_rdy <= 1'b1;
            if (word_rdy && !ack) begin
                overrun <= 1'b1;
            end
        end else if (ack) begin
            word_rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/scanline_binarizer.sv
module scanline_binarizer #(
    parameter int SMP_W  = 8,
    parameter int THR_W  = 5,
    parameter int DIV_W  = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  video_in,
    input  logic              hblank,
    input  logic              vblank,
    input  logic [DIV_W-1:0]  div_word,
    input  logic [THR_W-1:0]  thr_code,
    input  logic              word_ack,
    output logic [WORD_W-1:0] word_out,
    output logic              word_rdy,
    output logic              overrun
);
    import slc_pkg::*;

    phase_t            phase;
    logic              blank;
    logic              tick;
    logic [DIV_W-1:0]  slot_cnt;
    logic              buf_load;
    logic [WORD_W-1:0] buf_word;

    assign blank = hblank | vblank;
    assign phase = blank ? PH_BLANK : PH_ACTIVE;

    slc_slot_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .div_word (div_word),
        .tick     (tick),
        .cnt      (slot_cnt)
    );

    slc_packer #(.SMP_W(SMP_W), .THR_W(THR_W), .WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .tick      (tick),
        .video_in  (video_in),
        .thr_code  (thr_code),
        .load      (buf_load),
        .load_word (buf_word)
    );

    slc_out_buf #(.WORD_W(WORD_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (buf_load),
        .load_word (buf_word),
        .ack       (word_ack),
        .word_out  (word_out),
        .word_rdy  (word_rdy),
        .overrun   (overrun)
    );
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
    parameter int DIV_W  = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              blank,
    input logic [DIV_W-1:0]  div_word,
    input logic [DIV_W-1:0]  slot_cnt,
    input logic              buf_load,
    input logic [WORD_W-1:0] word_out,
    input logic              word_rdy,
    input logic              word_ack,
    input logic              overrun
);
    // R8 / R1: timer is held at the divider value during blanking
    a_r8_timer_held: assert property (@(posedge clk) disable iff (rst)
        blank |=> slot_cnt == $past(div_word));

    // R6: a new word always raises the ready flag
    a_r6_load_sets_rdy: assert property (@(posedge clk) disable iff (rst)
        buf_load |=> word_rdy);

    // R6: ready and data hold until acknowledged
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (word_rdy && !word_ack && !buf_load) |=> (word_rdy && $stable(word_out)));

    // R7: overrun never clears once set
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R7: overrun only rises from a load onto an unacknowledged word
    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> ($past(buf_load) && $past(word_rdy) && !$past(word_ack)));
endmodule

bind scanline_binarizer slc_checker #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .blank    (blank),
    .div_word (div_word),
    .slot_cnt (slot_cnt),
    .buf_load (buf_load),
    .word_out (word_out),
    .word_rdy (word_rdy),
    .word_ack (word_ack),
    .overrun  (overrun)
);

// File: tb/test_scanline_binarizer.sv
module test_scanline_binarizer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  video_in = '0;
    logic        hblank = 1'b1;
    logic        vblank = 1'b0;
    logic [7:0]  div_word = '0;
    logic [4:0]  thr_code = '0;
    logic        word_ack = 1'b0;
    logic [15:0] word_out;
    logic        word_rdy;
    logic        overrun;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic        ack_en = 1'b1;
    logic [15:0] exp_words [0:7];
    int exp_n = 0;
    int got_n = 0;

    always #4 clk = ~clk;

    scanline_binarizer i_scanline_binarizer (
        .clk(clk), .rst(rst), .video_in(video_in), .hblank(hblank), .vblank(vblank),
        .div_word(div_word), .thr_code(thr_code), .word_ack(word_ack),
        .word_out(word_out), .word_rdy(word_rdy), .overrun(overrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // consumer: take each word seen ready, compare in order, acknowledge (R4 R5 R6)
    always @(negedge clk) begin
        if (ack_en && word_rdy && !word_ack) begin
            if (got_n < exp_n)
                check(word_out == exp_words[got_n], "R4/R5 word", word_out, exp_words[got_n]);
            else
                check(1'b0, "R5 extra word", word_out, 0);
            got_n++;
            word_ack = 1'b1;
        end else begin
            word_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic bit pat(input int s, input int seed);
        return ((s * 7 + seed) % 3) == 0;
    endfunction

    // one line: blanking with high video (R8), active slots (R1 R2 R3), partial slot (R5)
    task automatic run_line(input int d, input int thr, input int nslots, input int seed);
        int lvl;
        int extra;
        lvl = thr * 8;
        for (int w = 0; w < 8; w++) exp_words[w] = '0;
        for (int s = 0; s < nslots; s++)
            if (pat(s, seed)) exp_words[s / 16][s % 16] = 1'b1;
        exp_n = slc_pkg::words_for(nslots, 16);
        got_n = 0;
        @(negedge clk);
        hblank = 1'b1;
        div_word = d[7:0];
        thr_code = thr[4:0];
        video_in = 8'hFF;
        repeat (4) @(negedge clk);
        hblank = 1'b0;
        for (int k = 0; k < nslots * (d + 1); k++) begin
            int s;
            int off;
            s = k / (d + 1);
            off = k % (d + 1);
            video_in = (pat(s, seed) && off == (s * 3) % (d + 1)) ? 8'(lvl + 1) : 8'(lvl);
            @(negedge clk);
        end
        extra = d;
        for (int k = 0; k < extra; k++) begin
            video_in = 8'hFF;
            @(negedge clk);
        end
        hblank = 1'b1;
        video_in = 8'hFF;
        repeat (6) @(negedge clk);
        if (ack_en)
            check(got_n == exp_n, "R5 word count", got_n, exp_n);
    endtask

    initial begin
        int dv [4] = '{0, 1, 3, 7};
        int tv [3] = '{0, 5, 31};
        int nv [4] = '{8, 16, 20, 96};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(word_out == 16'h0, "R9 word_out", word_out, 0);
        check(word_rdy == 1'b0, "R9 word_rdy", word_rdy, 0);
        check(overrun == 1'b0, "R9 overrun", overrun, 0);

        // vblank alone also blanks: high video produces no word (R8)
        vblank = 1'b1;
        hblank = 1'b0;
        video_in = 8'hFF;
        repeat (40) @(negedge clk);
        check(word_rdy == 1'b0, "R8 vblank ignore", word_rdy, 0);
        vblank = 1'b0;
        hblank = 1'b1;

        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++)
                for (int c = 0; c < 4; c++)
                    run_line(dv[a], tv[b], nv[c], a + b + c);
        check(overrun == 1'b0, "R7 no overrun with prompt ack", overrun, 0);

        // overrun: two words with no acknowledge (R7)
        ack_en = 1'b0;
        run_line(0, 2, 32, 1);
        check(overrun == 1'b1, "R7 overrun set", overrun, 1);
        check(word_rdy == 1'b1, "R6 rdy held", word_rdy, 1);
        check(word_out == exp_words[1], "R7 newer word kept", word_out, exp_words[1]);
        repeat (5) @(negedge clk);
        check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
        check(word_out == exp_words[1], "R6 word stable", word_out, exp_words[1]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule